// File: doc/BRIEF.md
# Frame-Aligned Video Source Switch with Stall Timeout

This block chooses which of two pixel streams reaches a single ready/valid streaming output. One source is an external live stream. The other is a solid blue frame built inside the block. Every beat carries a start-of-frame and an end-of-frame marker. A change of the select input is normally applied only between frames, so a frame that has started on the output always finishes whole.

If the live stream stops in the middle of a frame while a change to blue is pending, a watchdog counts idle cycles. When the programmed limit is reached, the block closes the broken output frame with a single end-of-frame beat. It then starts a fresh blue frame and throws away the rest of the abandoned live frame. A status bit shows which source is active, and a sticky flag records that a forced change has happened since reset. A limit of about one million cycles fits the default counter width.

Top module: `vss_switch`

## Requirements
- R1: During and right after reset, `out_valid`, `live_ready`, `src_live` and `forced_seen` are all 0, and the blue source is the active one.
- R2: A blue frame is exactly FRAME_W*FRAME_H beats long. Every beat carries pixel 0x0000FF in `out_data[23:0]`. `out_sop` is set on the first beat only and `out_eop` on the last beat only.
- R3: A change of `sel_live` takes effect only once the output frame in progress has ended with its end-of-frame beat. The next output frame comes whole from the new source.
- R4: Before any forced change, the live input sees `live_ready` low whenever blue is the active source.
- R5: While live is active, each accepted live beat of a frame appears on the output unchanged in data, start marker and end marker, in arrival order. Live beats that arrive with no output frame open and without a start marker are dropped.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high, with `out_data`, `out_sop` and `out_eop` unchanged.
- R7: The stall counter runs only while live is active, a change to blue is requested and an output frame is open. Every accepted live beat clears it. The forced change starts timeout_cycles+1 cycles after the last accepted live beat. Gaps shorter than the limit never force a change.
- R8: A forced change emits exactly one beat with `out_sop`=0, `out_eop`=1 and the blue pixel. The next output beat begins a complete blue frame.
- R9: After a forced change, `live_ready` is high for the abandoned live stream until a live beat with `live_eop` is accepted, and none of those beats reach the output. After that, `live_ready` returns low while blue stays selected.
- R10: `src_live` is 1 exactly while live is the active source. `forced_seen` goes to 1 on a forced change and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_live | input | 1 | Requested source: 1 live, 0 blue |
| timeout_cycles | input | TW | Idle cycles tolerated mid-frame before a forced change |
| live_valid | input | 1 | Live beat present |
| live_ready | output | 1 | Live beat accepted this cycle when valid |
| live_data | input | DW | Live pixel |
| live_sop | input | 1 | Live start-of-frame marker |
| live_eop | input | 1 | Live end-of-frame marker |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DW | Output pixel |
| out_sop | output | 1 | Output start-of-frame marker |
| out_eop | output | 1 | Output end-of-frame marker |
| src_live | output | 1 | Active source is live |
| forced_seen | output | 1 | Sticky: a forced change occurred |

## Verification
The bench builds the block with a 4x3 blue frame, so a whole frame is only 12 beats. This lets many frame boundaries fall at random points of a select change, and the whole frame contents can be compared beat by beat. TW is 8 and the limit is set to 16 cycles. This makes the forced change reachable within a few dozen cycles, so its exact start can be measured. Live frames with gaps of up to three cycles show that short stalls never trip the watchdog.

// File: rtl/vss_pkg.sv
package vss_pkg;
   typedef enum logic [1:0] {
      SRC_BLUE  = 2'd0,
      SRC_LIVE  = 2'd1,
      SRC_FLUSH = 2'd2
   } src_state_t;

   localparam int unsigned RGB_W = 24;
endpackage

// File: rtl/vss_blue_gen.sv
module vss_blue_gen #(
   parameter int unsigned DW       = 24,
   parameter int unsigned FRAME_W  = 64,
   parameter int unsigned FRAME_H  = 48,
   parameter logic [23:0] BLUE_RGB = 24'h0000FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   output logic [DW-1:0] pix,
   output logic          first,
   output logic          last
);
   localparam int unsigned XW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
   localparam int unsigned YW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;

   logic x_first, x_last, y_first, y_last;

   generate
      if (FRAME_W < 1 || FRAME_H < 1) begin : g_bad_size
         $error("vss_blue_gen: frame dimensions must be at least 1");
      end
      if (DW < vss_pkg::RGB_W) begin : g_bad_dw
         $error("vss_blue_gen: DW must hold a 24-bit pixel");
      end

      if (FRAME_W > 1) begin : g_col
         logic [XW-1:0] x_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       x_q <= '0;
            else if (advance) x_q <= x_last ? '0 : x_q + 1'b1;
         end
         assign x_first = (x_q == '0);
         assign x_last  = (x_q == XW'(FRAME_W - 1));
      end else begin : g_col_one
         assign x_first = 1'b1;
         assign x_last  = 1'b1;
      end

      if (FRAME_H > 1) begin : g_row
         logic [YW-1:0] y_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                 y_q <= '0;
            else if (advance && x_last) y_q <= y_last ? '0 : y_q + 1'b1;
         end
         assign y_first = (y_q == '0);
         assign y_last  = (y_q == YW'(FRAME_H - 1));
      end else begin : g_row_one
         assign y_first = 1'b1;
         assign y_last  = 1'b1;
      end
   endgenerate

   assign pix   = DW'(BLUE_RGB);
   assign first = x_first && y_first;
   assign last  = x_last && y_last;
endmodule

// File: rtl/vss_timeout.sv
module vss_timeout #(
   parameter int unsigned TW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          kick,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   logic [TW-1:0] idle_q;

   generate
      if (TW < 2) begin : g_bad_tw
         $error("vss_timeout: TW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              idle_q <= '0;
      else if (!arm || kick)   idle_q <= '0;
      else if (idle_q != '1)   idle_q <= idle_q + 1'b1;
   end

   assign expired = arm && (idle_q >= limit);
endmodule

// File: rtl/vss_out_stage.sv
module vss_out_stage #(
   parameter int unsigned DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] in_data,
   input  logic          in_sop,
   input  logic          in_eop,
   input  logic          out_ready,
   output logic          can_load,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_sop,
   output logic          out_eop
);
   logic          v_q;
   logic [DW-1:0] d_q;
   logic          s_q, e_q;

   assign can_load = !v_q || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)        v_q <= 1'b0;
      else if (can_load) v_q <= push;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_q <= '0;
         s_q <= 1'b0;
         e_q <= 1'b0;
      end else if (can_load && push) begin
         d_q <= in_data;
         s_q <= in_sop;
         e_q <= in_eop;
      end
   end

   assign out_valid = v_q;
   assign out_data  = d_q;
   assign out_sop   = s_q;
   assign out_eop   = e_q;
endmodule

// File: rtl/vss_switch.sv
module vss_switch #(
   parameter int unsigned DW       = 24,
   parameter int unsigned TW       = 20,
   parameter int unsigned FRAME_W  = 64,
   parameter int unsigned FRAME_H  = 48,
   parameter logic [23:0] BLUE_RGB = 24'h0000FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_live,
   input  logic [TW-1:0] timeout_cycles,
   input  logic          live_valid,
   output logic          live_ready,
   input  logic [DW-1:0] live_data,
   input  logic          live_sop,
   input  logic          live_eop,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic          out_sop,
   output logic          out_eop,
   output logic          src_live,
   output logic          forced_seen
);
   import vss_pkg::*;

   localparam int unsigned FRAME_PIX = FRAME_W * FRAME_H;

   generate
      if (FRAME_PIX < 2) begin : g_bad_frame
         $error("vss_switch: a blue frame needs at least two beats");
      end
   endgenerate

   src_state_t st_q;
   logic in_frame_q, drain_q, forced_q;

   logic          can_load, push;
   logic [DW-1:0] p_data;
   logic          p_sop, p_eop;
   logic [DW-1:0] b_pix;
   logic          b_first, b_last, b_adv;
   logic          ready_c, expired, arm, kick;
   logic          cur_live, take_switch;

   assign cur_live    = (st_q == SRC_LIVE);
   assign take_switch = !in_frame_q && (st_q != SRC_FLUSH) && (sel_live != cur_live);
   assign arm         = cur_live && !sel_live && in_frame_q;
   assign kick        = live_valid && ready_c;

   vss_blue_gen #(
      .DW(DW), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .BLUE_RGB(BLUE_RGB)
   ) u_blue (
      .clk(clk), .rst_n(rst_n), .advance(b_adv),
      .pix(b_pix), .first(b_first), .last(b_last)
   );

   vss_timeout #(.TW(TW)) u_tmo (
      .clk(clk), .rst_n(rst_n), .arm(arm), .kick(kick),
      .limit(timeout_cycles), .expired(expired)
   );

   vss_out_stage #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .push(push),
      .in_data(p_data), .in_sop(p_sop), .in_eop(p_eop),
      .out_ready(out_ready), .can_load(can_load),
      .out_valid(out_valid), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop)
   );

   always_comb begin
      push    = 1'b0;
      p_data  = b_pix;
      p_sop   = 1'b0;
      p_eop   = 1'b0;
      b_adv   = 1'b0;
      ready_c = 1'b0;
      case (st_q)
         SRC_BLUE: begin
            ready_c = drain_q;
            if (!take_switch && can_load) begin
               push  = 1'b1;
               p_sop = b_first;
               p_eop = b_last;
               b_adv = 1'b1;
            end
         end
         SRC_LIVE: begin
            if (!take_switch && !expired) begin
               ready_c = can_load;
               if (live_valid && can_load && (in_frame_q || live_sop)) begin
                  push   = 1'b1;
                  p_data = live_data;
                  p_sop  = live_sop;
                  p_eop  = live_eop;
               end
            end
         end
         SRC_FLUSH: begin
            ready_c = drain_q;
            if (can_load) begin
               push  = 1'b1;
               p_eop = 1'b1;
            end
         end
         default: ready_c = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= SRC_BLUE;
         forced_q <= 1'b0;
      end else if (take_switch) begin
         st_q <= sel_live ? SRC_LIVE : SRC_BLUE;
      end else if (cur_live && expired) begin
         st_q     <= SRC_FLUSH;
         forced_q <= 1'b1;
      end else if (st_q == SRC_FLUSH && can_load) begin
         st_q <= SRC_BLUE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    in_frame_q <= 1'b0;
      else if (push) in_frame_q <= !p_eop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                  drain_q <= 1'b0;
      else if (cur_live && expired)                drain_q <= 1'b1;
      else if (take_switch && sel_live)            drain_q <= 1'b0;
      else if (drain_q && kick && live_eop)        drain_q <= 1'b0;
   end

   assign live_ready  = ready_c;
   assign src_live    = cur_live;
   assign forced_seen = forced_q;
endmodule

// File: rtl/vss_switch_chk.sv
module vss_switch_chk #(
   parameter int unsigned DW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data,
   input logic          out_sop,
   input logic          out_eop,
   input logic          live_ready,
   input logic          src_live,
   input logic          forced_seen,
   input logic          blue_quiet,
   input logic          in_frame,
   input logic          flush_push
);
   AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))); // R6

   AST_QUIET_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      blue_quiet |-> !live_ready); // R4

   AST_STICKY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      forced_seen |=> forced_seen); // R10

   AST_FLUSH_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      flush_push |=> (out_valid && out_eop && !out_sop)); // R8

   AST_LIVE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_live) |-> $past(!in_frame)); // R3
endmodule

bind vss_switch vss_switch_chk #(.DW(DW)) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data(out_data),
   .out_sop(out_sop),
   .out_eop(out_eop),
   .live_ready(live_ready),
   .src_live(src_live),
   .forced_seen(forced_seen),
   .blue_quiet((st_q == vss_pkg::SRC_BLUE) && !drain_q),
   .in_frame(in_frame_q),
   .flush_push((st_q == vss_pkg::SRC_FLUSH) && can_load)
);

// File: tb/vss_switch_bench.sv
module vss_switch_bench;
   localparam int DW = 24;
   localparam int TW = 8;
   localparam int FW = 4;
   localparam int FH = 3;
   localparam int FP = FW * FH;
   localparam int LIM = 16;
   localparam logic [23:0] BLUE = 24'h0000FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_live = 1'b0;
   logic [TW-1:0] timeout_cycles = TW'(LIM);
   logic live_valid = 1'b0;
   logic live_ready;
   logic [DW-1:0] live_data = '0;
   logic live_sop = 1'b0;
   logic live_eop = 1'b0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [DW-1:0] out_data;
   logic out_sop, out_eop, src_live, forced_seen;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit rdy_rand = 1'b0;
   int n_out = 0;
   logic [DW-1:0] ob_d [0:4095];
   bit ob_s [0:4095];
   bit ob_e [0:4095];
   bit hold_pend = 1'b0;
   logic [DW-1:0] hd;
   bit hs, he;

   vss_switch #(.DW(DW), .TW(TW), .FRAME_W(FW), .FRAME_H(FH), .BLUE_RGB(BLUE)) u_vss_switch (
      .clk(clk), .rst_n(rst_n), .sel_live(sel_live), .timeout_cycles(timeout_cycles),
      .live_valid(live_valid), .live_ready(live_ready), .live_data(live_data),
      .live_sop(live_sop), .live_eop(live_eop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop),
      .src_live(src_live), .forced_seen(forced_seen)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) out_ready = rdy_rand ? (($urandom % 100) < 70) : 1'b1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   always begin
      @(negedge clk);
      #3;
      if (rst_n) begin
         if (hold_pend)
            chk(out_valid && out_data == hd && out_sop == hs && out_eop == he, "R6",
                "held beat changed", {out_valid, out_sop, out_eop, out_data},
                {1'b1, hs, he, hd});
         hold_pend = out_valid && !out_ready;
         hd = out_data; hs = out_sop; he = out_eop;
         if (!forced_seen && !src_live)
            chk(!live_ready, "R4", "live_ready while blue", live_ready, 0);
         if (out_valid && out_ready && n_out < 4096) begin
            ob_d[n_out] = out_data;
            ob_s[n_out] = out_sop;
            ob_e[n_out] = out_eop;
            n_out++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   task automatic wait_out(input int n);
      while (n_out < n) @(negedge clk);
      #4;
   endtask

   function automatic logic [63:0] beat(input logic [DW-1:0] d, input bit s, input bit e);
      return {38'd0, s, e, d};
   endfunction

   task automatic check_blue(input int st, input string req);
      for (int k = 0; k < FP; k++)
         chk(ob_d[st+k] == BLUE && ob_s[st+k] == (k == 0) && ob_e[st+k] == (k == FP-1),
             req, $sformatf("blue beat %0d", st+k),
             beat(ob_d[st+k], ob_s[st+k], ob_e[st+k]), beat(BLUE, k == 0, k == FP-1));
   endtask

   task automatic check_live(input int st, input logic [DW-1:0] base, input int nb,
                             input int len, input string req);
      for (int k = 0; k < nb; k++)
         chk(ob_d[st+k] == base + DW'(k) && ob_s[st+k] == (k == 0) && ob_e[st+k] == (k == len-1),
             req, $sformatf("live beat %0d", st+k),
             beat(ob_d[st+k], ob_s[st+k], ob_e[st+k]),
             beat(base + DW'(k), k == 0, k == len-1));
   endtask

   // drives live beats k0..k1-1 of a len-beat frame; begins and ends at a falling edge
   task automatic send(input logic [DW-1:0] base, input int k0, input int k1, input int len,
                       input int sel_at, input bit sel_val, input int maxgap,
                       output int last_cyc);
      bit acc;
      for (int k = k0; k < k1; k++) begin
         repeat ($urandom % (maxgap + 1)) begin
            live_valid = 1'b0;
            @(negedge clk);
         end
         live_valid = 1'b1;
         live_data  = base + DW'(k);
         live_sop   = (k == 0);
         live_eop   = (k == len - 1);
         acc = 1'b0;
         while (!acc) begin
            #1;
            acc = live_ready;
            @(negedge clk);
         end
         last_cyc = cyc;
         if (k == sel_at) sel_live = sel_val;
      end
      live_valid = 1'b0;
      live_sop   = 1'b0;
      live_eop   = 1'b0;
   endtask

   initial begin
      int mark, fs, st, s7, lc, fc;
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      #1;
      chk(!out_valid && !live_ready && !src_live && !forced_seen, "R1", "reset state",
          {out_valid, live_ready, src_live, forced_seen}, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!out_valid && !src_live && !forced_seen, "R1", "after release",
          {out_valid, src_live, forced_seen}, 3'b000);

      // blue frames under random downstream back-pressure
      rdy_rand = 1'b1;
      wait_out(2 * FP);
      check_blue(0, "R2");
      check_blue(FP, "R2");

      // request live in the middle of a blue frame
      forever begin
         @(negedge clk);
         #4;
         if (n_out % FP == 5) break;
      end
      mark = n_out;
      sel_live = 1'b1;
      fs = (mark / FP + 1) * FP;
      send(24'h100000, 0, 10, 10, -1, 1'b0, 2, lc);
      wait_out(fs + 10);
      check_blue(fs - FP, "R3");
      check_live(fs, 24'h100000, 10, 10, "R5");
      chk(src_live == 1'b1, "R10", "src_live after switch", src_live, 1);

      // live pass-through with gaps and back-pressure
      st = n_out;
      send(24'h200000, 0, 20, 20, -1, 1'b0, 3, lc);
      wait_out(st + 20);
      check_live(st, 24'h200000, 20, 20, "R5");

      // return to blue at the live frame's end; short gaps never force
      rdy_rand = 1'b0;
      st = n_out;
      send(24'h300000, 0, 15, 15, 4, 1'b0, 3, lc);
      wait_out(st + 15 + FP);
      check_live(st, 24'h300000, 15, 15, "R3");
      check_blue(st + 15, "R3");
      chk(forced_seen == 1'b0, "R7", "no force with short gaps", forced_seen, 0);
      chk(src_live == 1'b0, "R10", "src_live after return", src_live, 0);

      // live stream stalls mid-frame while blue is requested
      mark = n_out;
      sel_live = 1'b1;
      send(24'hA00000, 0, 6, 20, 2, 1'b0, 0, lc);
      fc = lc;
      while (!forced_seen) begin
         @(negedge clk);
         #1;
         fc = cyc;
      end
      chk(fc - lc >= LIM && fc - lc <= LIM + 2, "R7", "force delay", fc - lc, LIM + 1);
      chk(live_ready == 1'b1, "R9", "drain ready", live_ready, 1);
      chk(src_live == 1'b0, "R10", "src_live after force", src_live, 0);
      @(negedge clk);
      send(24'hA00000, 6, 20, 20, -1, 1'b0, 0, lc);
      #1;
      chk(live_ready == 1'b0, "R9", "ready after drain", live_ready, 0);
      s7 = -1;
      for (int i = mark; i < n_out; i++)
         if (s7 < 0 && ob_d[i] == 24'hA00000 && ob_s[i]) s7 = i;
      chk(s7 >= 0, "R5", "live frame start found", s7 >= 0, 1);
      if (s7 < 0) s7 = mark;
      wait_out(s7 + 7 + 2 * FP);
      check_live(s7, 24'hA00000, 6, 20, "R5");
      chk(!ob_s[s7+6] && ob_e[s7+6] && ob_d[s7+6] == BLUE, "R8", "closing beat",
          beat(ob_d[s7+6], ob_s[s7+6], ob_e[s7+6]), beat(BLUE, 1'b0, 1'b1));
      check_blue(s7 + 7, "R8");
      check_blue(s7 + 7 + FP, "R9");
      chk(forced_seen == 1'b1, "R10", "sticky flag held", forced_seen, 1);

      // reset clears the sticky flag
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      #1;
      chk(forced_seen == 1'b0 && !out_valid, "R10", "sticky cleared by reset",
          {forced_seen, out_valid}, 2'b00);

      summary();
      $finish;
   end
endmodule